// File: doc/BRIEF.md
# DMA Stream Interrupt Flag Collector

This block keeps the interrupt events of four DMA streams. Each stream reports five kinds of event: the first half of a transfer is done, the whole transfer is done, a bus error, a FIFO fault (overrun, underrun or bad level), and a fault in direct mode. Each event arrives as a one-cycle hardware pulse and sets a sticky flag. Software reads the flags as one 32-bit word. It clears a flag by writing a one to the same bit of a separate clear word.

An enable word uses the same bit layout as the flags. It selects which flags reach each stream's interrupt line. Each stream line is registered. One more output is the OR of all four stream lines. Registers are addressed by byte offset and accessed only as whole 32-bit words. The low two address bits are ignored.

Top module: `dma_event_flags`

## Requirements
- R1: After reset the flag word and the enable word read 0x00000000, and `irq_stream` and `irq_any` are low.
- R2: Inside each stream's 6-bit group the FIFO-fault flag is at offset 0 and offset 1 is unused. The direct-mode fault is at 2, the bus error at 3, half-done at 4 and transfer-done at 5. The groups start at bits 0, 6, 16 and 22 for streams 0 to 3.
- R3: An event pulse sampled at a clock edge sets its flag at that edge. The flag is visible in the flag word from then on and stays set until it is cleared.
- R4: A write to the clear word (offset 0x4) clears every flag whose bit is 1 in the write data. Bits written as 0 leave their flags unchanged.
- R5: Writes to the flag word (offset 0x0) have no effect.
- R6: When an event pulse and a clear of the same flag fall in the same cycle, the flag stays set.
- R7: Reserved bit positions (offset 1 of every group, 15:12 and 31:28) always read 0 in the flag word and in the enable word, whatever is written to them.
- R8: Reads of the clear word return 0.
- R9: The enable word is at offset 0x8, can be written and read back, and uses the same layout as the flag word. Reads of any other offset return 0.
- R10: `irq_stream[s]` is high one cycle after stream s has at least one flag whose enable bit is also set. This includes the case where the enable is set after the flag. The line drops one cycle after no such pair is left.
- R11: `irq_any` is high exactly when at least one bit of `irq_stream` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_fifo_err | input | 4 | FIFO fault pulse, one bit per stream |
| evt_direct_err | input | 4 | Direct-mode fault pulse, one bit per stream |
| evt_xfer_err | input | 4 | Bus error pulse, one bit per stream |
| evt_half | input | 4 | Half-done pulse, one bit per stream |
| evt_done | input | 4 | Transfer-done pulse, one bit per stream |
| wr_en | input | 1 | Word write strobe |
| addr | input | 4 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_stream | output | 4 | Registered interrupt line for each stream |
| irq_any | output | 1 | OR of all stream lines |

## Verification
The bench goes after the uneven packing first. It fires each of the twenty sources alone and expects exactly one bit at its own position. A design that put the reserved hole in the wrong place, or that packed the groups tightly, would light the wrong bit.

A design that let the clear win would lose the flag when an event and a clear land together. A design that cleared on written zeros would wipe out neighbouring flags.

A design that sampled the enable only when an event arrives would miss the case where the enable is set after the flag. A design that did not register the stream lines would raise them one cycle early.

Reserved bits are written with all ones to catch storage that leaks into the unused holes. The flag word is also written directly, to catch a design that accepts that write.

// File: rtl/dma_event_flags.sv
module dma_event_flags #(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int CLEAR_OFS  = 4,
  parameter int ENABLE_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        evt_fifo_err,
  input  logic [3:0]        evt_direct_err,
  input  logic [3:0]        evt_xfer_err,
  input  logic [3:0]        evt_half,
  input  logic [3:0]        evt_done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [3:0]        irq_stream,
  output logic              irq_any
);
  localparam int NSTREAM = 4;
  localparam int NSRC    = 5;

  function automatic int grp_base(int s);
    return (s % 2) * 6 + (s / 2) * 16;
  endfunction

  function automatic int bit_pos(int s, int k);
    return grp_base(s) + ((k == 0) ? 0 : k + 1);
  endfunction

  function automatic logic [31:0] grp_mask(int s);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < NSRC; k++) m[bit_pos(s, k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] all_mask();
    logic [31:0] m;
    m = '0;
    for (int s = 0; s < NSTREAM; s++) m = m | grp_mask(s);
    return m;
  endfunction

  localparam logic [31:0] VALID = all_mask();

  logic [NSRC-1:0][NSTREAM-1:0] evt_all;
  logic [31:0] set_vec, clr_vec, flag_q, en_q;
  logic [NSTREAM-1:0] hit;
  logic [ADDR_W-1:2] word;

  assign evt_all = {evt_done, evt_half, evt_xfer_err, evt_direct_err, evt_fifo_err};
  assign word    = addr[ADDR_W-1:2];

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NSTREAM; s++)
      for (int k = 0; k < NSRC; k++)
        set_vec[bit_pos(s, k)] = evt_all[k][s];
  end

  assign clr_vec = (wr_en && word == CLEAR_OFS[ADDR_W-1:2]) ? (wdata & VALID) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | set_vec;
      if (wr_en && word == ENABLE_OFS[ADDR_W-1:2])
        en_q <= wdata & VALID;
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_irq
    assign hit[s] = |(flag_q & en_q & grp_mask(s));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_stream <= '0;
    else        irq_stream <= hit;
  end

  assign irq_any = |irq_stream;

  always_comb begin
    rdata = '0;
    if (word == STATUS_OFS[ADDR_W-1:2])      rdata = flag_q;
    else if (word == ENABLE_OFS[ADDR_W-1:2]) rdata = en_q;
  end

  // R3 R6
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R4
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != 0) |=> ((flag_q & $past(clr_vec) & ~$past(set_vec)) == 0));

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == 0 && clr_vec == 0) |=> $stable(flag_q));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q | en_q) & ~VALID) == 0);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) == 0) |=> (irq_stream == 0));
endmodule

// File: tb/sim_dma_event_flags.sv
module sim_dma_event_flags;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] evt [5];
  logic [31:0] rdata;
  logic [3:0] irq_stream;
  logic irq_any;
  int errors = 0, checks = 0;

  // entry: {stream[9:8], source[7:5], expected bit[4:0]}; source 0 fifo,1 direct,2 xfer,3 half,4 done
  localparam logic [9:0] VEC [20] = '{
    {2'd0,3'd0,5'd0},  {2'd0,3'd1,5'd2},  {2'd0,3'd2,5'd3},  {2'd0,3'd3,5'd4},  {2'd0,3'd4,5'd5},
    {2'd1,3'd0,5'd6},  {2'd1,3'd1,5'd8},  {2'd1,3'd2,5'd9},  {2'd1,3'd3,5'd10}, {2'd1,3'd4,5'd11},
    {2'd2,3'd0,5'd16}, {2'd2,3'd1,5'd18}, {2'd2,3'd2,5'd19}, {2'd2,3'd3,5'd20}, {2'd2,3'd4,5'd21},
    {2'd3,3'd0,5'd22}, {2'd3,3'd1,5'd24}, {2'd3,3'd2,5'd25}, {2'd3,3'd3,5'd26}, {2'd3,3'd4,5'd27}};

  dma_event_flags u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_fifo_err(evt[0]), .evt_direct_err(evt[1]), .evt_xfer_err(evt[2]),
    .evt_half(evt[3]), .evt_done(evt[4]),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_stream(irq_stream), .irq_any(irq_any));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(int s, int k);
    @(negedge clk); evt[k][s] = 1'b1;
    @(negedge clk); for (int j = 0; j < 5; j++) evt[j] = '0;
  endtask

  initial begin
    logic [31:0] d;
    for (int j = 0; j < 5; j++) evt[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, d); chk("R1 flags", d, 0);
    rd(4'h8, d); chk("R1 enable", d, 0);
    chk("R1 irq", {27'd0, irq_any, irq_stream}, 0);

    for (int i = 0; i < 20; i++) begin
      pulse(int'(VEC[i][9:8]), int'(VEC[i][7:5]));
      rd(4'h0, d); chk("R2 R3 position", d, 32'd1 << VEC[i][4:0]);
      wr(4'h4, 32'd1 << VEC[i][4:0]);
      rd(4'h0, d); chk("R4 cleared", d, 0);
    end

    // R3 sticky + R4 zero bits ignored
    pulse(1, 4); pulse(3, 0);
    repeat (3) @(negedge clk);
    rd(4'h0, d); chk("R3 sticky", d, 32'h0040_0800);
    wr(4'h4, 32'h0000_0800);
    rd(4'h0, d); chk("R4 partial clear", d, 32'h0040_0000);
    wr(4'h4, 32'h0);
    rd(4'h0, d); chk("R4 zero write", d, 32'h0040_0000);

    // R5
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R5 flag write ignored", d, 32'h0040_0000);
    wr(4'h4, 32'hFFFF_FFFF);

    // R6 set wins
    @(negedge clk); evt[3][2] = 1'b1; wr_en = 1'b1; addr = 4'h4; wdata = 32'h0010_0000;
    @(negedge clk); evt[3][2] = 1'b0; wr_en = 1'b0; wdata = '0;
    rd(4'h0, d); chk("R6 set wins", d, 32'h0010_0000);

    // R7 R9
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R7 R9 enable readback", d, 32'h0F7D_0F7D);
    wr(4'h8, 32'h0);
    rd(4'h8, d); chk("R9 enable zero", d, 0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R7 flags reserved", d, 0);
    rd(4'h4, d); chk("R8 clear reads zero", d, 0);
    rd(4'hC, d); chk("R9 unmapped", d, 0);

    // R10 enable after flag
    pulse(2, 3);
    @(negedge clk);
    chk("R10 disabled stays low", {27'd0, irq_any, irq_stream}, 0);
    wr(4'h8, 32'h0010_0000);
    chk("R10 one-cycle latency", {28'd0, irq_stream}, 0);
    @(negedge clk);
    chk("R10 late enable", {28'd0, irq_stream}, 4'b0100);
    chk("R11 any", {31'd0, irq_any}, 1);
    wr(4'h4, 32'h0010_0000);
    chk("R10 still high one cycle", {28'd0, irq_stream}, 4'b0100);
    @(negedge clk);
    chk("R10 drop", {27'd0, irq_any, irq_stream}, 0);

    // R10 R11 several streams at once
    wr(4'h8, 32'h0F7D_0F7D);
    @(negedge clk); evt[0][0] = 1'b1; evt[4][3] = 1'b1;
    @(negedge clk); for (int j = 0; j < 5; j++) evt[j] = '0;
    chk("R10 latency multi", {28'd0, irq_stream}, 0);
    @(negedge clk);
    chk("R10 multi", {28'd0, irq_stream}, 4'b1001);
    chk("R11 multi", {31'd0, irq_any}, 1);
    wr(4'h8, 32'h0000_0001);
    @(negedge clk);
    chk("R10 enable removed", {28'd0, irq_stream}, 4'b0001);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'h0, d); chk("R1 reset flags", d, 0);
    chk("R1 reset irq", {27'd0, irq_any, irq_stream}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule